// File: doc/BRIEF.md
# Multiprocessor Device Interrupt Steering Controller

This block steers level-sensitive device interrupts to up to four processors. Every clock it samples 64 device request lines into a raw request register. A separate legacy-bus cascade input takes the place of one of those lines. Each processor owns a 64-bit enable mask. The processor's hardware interrupt output is raised while the AND of its mask and the raw register is nonzero.

A miscellaneous control register sits beside the masks. It holds the inter-processor interrupt pending bits, the interval-timer pending bits, two arbitration fields and a small read/write field. Each of these fields has its own write rule. Software reaches every register through a 64-bit read/write port addressed by byte offset. A read of the miscellaneous register also reports the index of the processor that issued the access. Offsets that belong to memory-timing, memory-programming and performance-monitor functions are decoded, read as zero and ignore writes. Every other offset is an access error.

Top module: `irq_steer_ctrl`

## Requirements
- R1: Raw bit n is the level of device line n one clock earlier. Bit 55 instead takes the legacy cascade input `legacy_irq`, and `dev_lvl[55]` has no effect.
- R2: The raw register reads at offset 0x300. The masked view of processor 0, 1, 2 and 3 (mask AND raw) reads at 0x280, 0x2C0, 0x680 and 0x6C0. A write to any of these five offsets changes nothing.
- R3: `hw_irq[i]` is high exactly when mask i AND raw is nonzero. It is re-evaluated in the same cycle that the raw register or mask i is updated.
- R4: The 64-bit masks of processors 0, 1, 2 and 3 are read/write at 0x200, 0x240, 0x600 and 0x640, and reset to zero.
- R5: A write to the miscellaneous register at 0x080 clears every stored bit that is 1 in both the write data and 0x10000FF0. These are timer-pending bits 7:4, inter-processor-pending bits 11:8 and bit 28.
- R6: A misc write with data bit 20 set clears stored bits 23:16.
- R7: A misc write with data bit 20 clear sets stored bits 23:20 wherever the data has a 1. The same write sets bits 19:16 the same way only when those four bits are currently all zero. If they are not all zero, bits 19:16 are left unchanged.
- R8: Write data bits 15:12 set pending bits 11:8. This set wins over a clear of the same bit in the same write. `ipi_irq[i]` follows stored bit 8+i.
- R9: Misc bits 43:40 are plain read/write. On reset the misc register holds only bit 35 (value 0x8_0000_0000).
- R10: A misc read returns the stored value ORed with `reg_cpu` in bits 1:0.
- R11: A pulse on `tmr_set[i]` sets misc bit 4+i, and `tmr_irq[i]` follows that bit. If `tmr_set[i]` and a misc write that clears bit 4+i fall in the same cycle, the bit ends up set.
- R12: An access to an unlisted offset, an offset not a multiple of 0x40, or an offset at or above 0x1000 has these effects. `reg_err` pulses for one cycle in the cycle after the request. A read of such an offset returns all ones, and a write to it changes no state. The decoded reserved offsets (for example 0x000 and 0x040) read zero without error. Read data appears on `reg_rdata` in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_req | input | 1 | Register access request, one cycle per access |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | AW (12) | Byte offset of the register |
| reg_wdata | input | 64 | Write data |
| reg_cpu | input | 2 | Index of the processor issuing the access |
| reg_rdata | output | 64 | Read data, valid the cycle after a read request |
| reg_err | output | 1 | One-cycle access-error pulse |
| dev_lvl | input | 64 | Level-sensitive device request lines |
| legacy_irq | input | 1 | Legacy-bus cascade interrupt level |
| tmr_set | input | NCPU (4) | Interval-timer tick per processor |
| hw_irq | output | NCPU (4) | Device interrupt per processor |
| ipi_irq | output | NCPU (4) | Inter-processor interrupt per processor |
| tmr_irq | output | NCPU (4) | Interval-timer interrupt per processor |

## Verification
A timer tick and a software write that clears the same timer-pending bit can land in the same clock. The bench drives `tmr_set` in the very cycle of a misc write that carries a 1 in that bit's position. It then expects the bit, and `tmr_irq`, to read back as set. The bench also moves a device line in the cycle before a mask write. It judges `hw_irq` right after that edge, against the new mask and the new raw value together.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;

   localparam int unsigned DW = 64;

   localparam logic [11:0] OFF_MISC = 12'h080;
   localparam logic [11:0] OFF_RAW  = 12'h300;

   // write-1-to-clear field set of the misc register
   localparam logic [DW-1:0] MISC_W1C   = 64'h0000_0000_1000_0FF0;
   // revision indicator held after reset
   localparam logic [DW-1:0] MISC_RESET = 64'h0000_0008_0000_0000;

   // per-processor mask offset: processors 0/1 in the low bank, 2/3 in the high bank
   function automatic logic [11:0] mask_off(int unsigned idx);
      logic [11:0] bank;
      bank = (idx < 2) ? 12'h200 : 12'h600;
      return bank + 12'((idx % 2) * 64);
   endfunction

   function automatic logic [11:0] view_off(int unsigned idx);
      return mask_off(idx) + 12'h080;
   endfunction

   // decoded offsets that read as zero and swallow writes
   function automatic logic is_quiet(logic [11:0] off);
      case (off)
         12'h000, 12'h040, 12'h0C0,
         12'h100, 12'h140, 12'h180, 12'h1C0,
         12'h340, 12'h380, 12'h3C0,
         12'h400, 12'h440, 12'h480, 12'h4C0,
         12'h580, 12'h5C0,
         12'h700, 12'h740, 12'h780,
         12'hC00, 12'hC40, 12'hC80, 12'hCC0: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/irq_raw_capture.sv
module irq_raw_capture
   import irq_steer_pkg::*;
#(
   parameter int unsigned LEGACY_BIT = 55
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] dev_lvl,
   input  logic          legacy_irq,
   output logic [DW-1:0] raw_q
);

   logic [DW-1:0] lines;

   generate
      if (LEGACY_BIT < DW) begin : g_cascade
         always_comb begin
            lines             = dev_lvl;
            lines[LEGACY_BIT] = legacy_irq;
         end
      end else begin : g_plain
         logic unused_legacy;
         assign unused_legacy = legacy_irq;
         assign lines         = dev_lvl;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) raw_q <= '0;
      else        raw_q <= lines;
   end

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
   import irq_steer_pkg::*;
#(
   parameter int unsigned NCPU = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NCPU-1:0]           wr_en,
   input  logic [DW-1:0]             wdata,
   input  logic [DW-1:0]             raw_q,
   output logic [NCPU-1:0][DW-1:0]   mask_q,
   output logic [NCPU-1:0]           hw_irq
);

   generate
      for (genvar i = 0; i < NCPU; i++) begin : g_cpu
         always_ff @(posedge clk) begin
            if (!rst_n)        mask_q[i] <= '0;
            else if (wr_en[i]) mask_q[i] <= wdata;
         end
         assign hw_irq[i] = |(mask_q[i] & raw_q);
      end
   endgenerate

endmodule

// File: rtl/irq_misc_reg.sv
module irq_misc_reg
   import irq_steer_pkg::*;
#(
   parameter int unsigned NCPU = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [DW-1:0]   wdata,
   input  logic [NCPU-1:0] tmr_set,
   output logic [DW-1:0]   misc_q,
   output logic [NCPU-1:0] ipi_irq,
   output logic [NCPU-1:0] tmr_irq
);

   logic [DW-1:0] nxt;

   always_comb begin
      nxt = misc_q;
      if (wr_en) begin
         nxt = nxt & ~(wdata & MISC_W1C);
         if (wdata[20]) begin
            nxt[23:16] = '0;
         end else begin
            nxt[23:20] = nxt[23:20] | wdata[23:20];
            if (nxt[19:16] == 4'b0000) nxt[19:16] = wdata[19:16];
         end
         nxt[11:8]  = nxt[11:8] | wdata[15:12];
         nxt[43:40] = wdata[43:40];
      end
      // hardware timer ticks land after the software update: set wins
      for (int i = 0; i < NCPU; i++) begin
         if (tmr_set[i]) nxt[4+i] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) misc_q <= MISC_RESET;
      else        misc_q <= nxt;
   end

   generate
      for (genvar i = 0; i < NCPU; i++) begin : g_out
         assign ipi_irq[i] = misc_q[8+i];
         assign tmr_irq[i] = misc_q[4+i];
      end
   endgenerate

endmodule

// File: rtl/irq_steer_ctrl.sv
module irq_steer_ctrl
   import irq_steer_pkg::*;
#(
   parameter int unsigned NCPU       = 4,
   parameter int unsigned AW         = 12,
   parameter int unsigned LEGACY_BIT = 55
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reg_req,
   input  logic            reg_wr,
   input  logic [AW-1:0]   reg_addr,
   input  logic [DW-1:0]   reg_wdata,
   input  logic [1:0]      reg_cpu,
   output logic [DW-1:0]   reg_rdata,
   output logic            reg_err,
   input  logic [DW-1:0]   dev_lvl,
   input  logic            legacy_irq,
   input  logic [NCPU-1:0] tmr_set,
   output logic [NCPU-1:0] hw_irq,
   output logic [NCPU-1:0] ipi_irq,
   output logic [NCPU-1:0] tmr_irq
);

   generate
      if (NCPU < 1 || NCPU > 4) begin : g_bad_ncpu
         $error("irq_steer_ctrl: NCPU must be 1..4");
      end
      if (AW < 12) begin : g_bad_aw
         $error("irq_steer_ctrl: AW must be at least 12");
      end
   endgenerate

   logic [DW-1:0]           raw_q;
   logic [DW-1:0]           misc_q;
   logic [NCPU-1:0][DW-1:0] mask_q;
   logic [NCPU-1:0]         mask_hit, view_hit, mask_we;
   logic [11:0]             off;
   logic [AW-1:0]           hi_bits;
   logic                    aligned, hit_misc, hit_raw, hit_quiet, mapped;
   logic [DW-1:0]           rd_val;

   assign off       = reg_addr[11:0];
   assign hi_bits   = reg_addr >> 12;
   assign aligned   = (hi_bits == '0) && (off[5:0] == 6'd0);
   assign hit_misc  = aligned && (off == OFF_MISC);
   assign hit_raw   = aligned && (off == OFF_RAW);
   assign hit_quiet = aligned && is_quiet(off);

   generate
      for (genvar i = 0; i < NCPU; i++) begin : g_dec
         assign mask_hit[i] = aligned && (off == mask_off(i));
         assign view_hit[i] = aligned && (off == view_off(i));
         assign mask_we[i]  = reg_req && reg_wr && mask_hit[i];
      end
   endgenerate

   assign mapped = hit_misc | hit_raw | hit_quiet | (|mask_hit) | (|view_hit);

   irq_raw_capture #(.LEGACY_BIT(LEGACY_BIT)) u_raw (
      .clk        (clk),
      .rst_n      (rst_n),
      .dev_lvl    (dev_lvl),
      .legacy_irq (legacy_irq),
      .raw_q      (raw_q)
   );

   irq_mask_bank #(.NCPU(NCPU)) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (mask_we),
      .wdata  (reg_wdata),
      .raw_q  (raw_q),
      .mask_q (mask_q),
      .hw_irq (hw_irq)
   );

   irq_misc_reg #(.NCPU(NCPU)) u_misc (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_req && reg_wr && hit_misc),
      .wdata   (reg_wdata),
      .tmr_set (tmr_set),
      .misc_q  (misc_q),
      .ipi_irq (ipi_irq),
      .tmr_irq (tmr_irq)
   );

   always_comb begin
      rd_val = '0;
      if (hit_misc) rd_val = misc_q | {{(DW-2){1'b0}}, reg_cpu};
      if (hit_raw)  rd_val = raw_q;
      for (int i = 0; i < NCPU; i++) begin
         if (mask_hit[i]) rd_val = mask_q[i];
         if (view_hit[i]) rd_val = mask_q[i] & raw_q;
      end
      if (!mapped) rd_val = '1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_rdata <= '0;
         reg_err   <= 1'b0;
      end else begin
         reg_err <= reg_req && !mapped;
         if (reg_req && !reg_wr) reg_rdata <= rd_val;
      end
   end

endmodule

// File: rtl/irq_steer_chk.sv
module irq_steer_chk
   import irq_steer_pkg::*;
#(
   parameter int unsigned NCPU = 4,
   parameter int unsigned AW   = 12
) (
   input logic            clk,
   input logic            rst_n,
   input logic            reg_req,
   input logic            reg_wr,
   input logic [AW-1:0]   reg_addr,
   input logic [DW-1:0]   reg_wdata,
   input logic [DW-1:0]   reg_rdata,
   input logic            reg_err,
   input logic [DW-1:0]   dev_lvl,
   input logic            legacy_irq,
   input logic [NCPU-1:0] tmr_set,
   input logic [NCPU-1:0] hw_irq,
   input logic [NCPU-1:0] tmr_irq,
   input logic [DW-1:0]   misc_q
);

   // R3: with every request line low, no processor sees a device interrupt
   p_quiet_lines_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_lvl == '0 && !legacy_irq) |=> (hw_irq == '0));

   // R12: misaligned offsets always raise the error pulse
   p_unaligned_err_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_req && reg_addr[5:0] != 6'd0) |=> reg_err);

   // R12: an error pulse only follows a request
   p_err_after_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
      reg_err |-> $past(reg_req));

   // R12: a failed read returns all ones
   p_err_ones_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_err && !$past(reg_wr)) |-> (reg_rdata == '1));

   // R6: the arbitration-clear bit empties bits 23:16
   p_arb_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_req && reg_wr && reg_addr == AW'(OFF_MISC) && reg_wdata[20])
      |=> (misc_q[23:16] == 8'h00));

   // R11: a timer tick always leaves the timer output raised
   p_timer_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_set != '0) |=> ((tmr_irq & $past(tmr_set)) == $past(tmr_set)));

   // R9: bit 35 cannot be cleared by any write
   p_rev_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      misc_q[35]);

endmodule

bind irq_steer_ctrl irq_steer_chk #(.NCPU(NCPU), .AW(AW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_req    (reg_req),
   .reg_wr     (reg_wr),
   .reg_addr   (reg_addr),
   .reg_wdata  (reg_wdata),
   .reg_rdata  (reg_rdata),
   .reg_err    (reg_err),
   .dev_lvl    (dev_lvl),
   .legacy_irq (legacy_irq),
   .tmr_set    (tmr_set),
   .hw_irq     (hw_irq),
   .tmr_irq    (tmr_irq),
   .misc_q     (misc_q)
);

// File: tb/irq_steer_ctrl_bench.sv
module irq_steer_ctrl_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_req = 1'b0, reg_wr = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [63:0] reg_wdata = '0;
   logic [1:0]  reg_cpu = '0;
   logic [63:0] reg_rdata;
   logic        reg_err;
   logic [63:0] dev_lvl = '0;
   logic        legacy_irq = 1'b0;
   logic [3:0]  tmr_set = '0;
   logic [3:0]  hw_irq, ipi_irq, tmr_irq;

   always #2 clk = ~clk;   // 250 MHz

   irq_steer_ctrl u_irq_steer_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_cpu(reg_cpu),
      .reg_rdata(reg_rdata), .reg_err(reg_err), .dev_lvl(dev_lvl),
      .legacy_irq(legacy_irq), .tmr_set(tmr_set), .hw_irq(hw_irq),
      .ipi_irq(ipi_irq), .tmr_irq(tmr_irq)
   );

   typedef struct {
      logic [63:0] data;
      logic        err;
      logic        chk_data;
      string       tag;
   } item_t;

   item_t       sb[$];
   int          n_cmp = 0, n_bad = 0;
   logic        acc_q = 1'b0;
   logic [63:0] exp_misc = 64'h0000_0008_0000_0000;
   logic        done = 1'b0;

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // misc write rules, from the requirement text
   function automatic logic [63:0] misc_apply(input logic [63:0] old, input logic [63:0] wd);
      logic [63:0] n;
      n = old & ~(wd & 64'h1000_0FF0);
      if (wd[20]) n[23:16] = 8'h00;
      else begin
         n[23:20] |= wd[23:20];
         if (n[19:16] == 4'h0) n[19:16] = wd[19:16];
      end
      n[11:8] |= wd[15:12];
      n[43:40] = wd[43:40];
      return n;
   endfunction

   // driver: one access, expected response pushed to the scoreboard
   task automatic acc(input logic wr, input logic [11:0] a, input logic [63:0] d,
                      input logic [1:0] cpu, input logic e, input logic cd,
                      input logic [63:0] ed, input string tag, input logic [3:0] ts);
      item_t it;
      @(negedge clk);
      reg_req = 1'b1; reg_wr = wr; reg_addr = a; reg_wdata = d; reg_cpu = cpu;
      tmr_set = ts;
      it.data = ed; it.err = e; it.chk_data = cd; it.tag = tag;
      sb.push_back(it);
      @(negedge clk);
      reg_req = 1'b0; reg_wr = 1'b0; tmr_set = '0;
   endtask

   task automatic rd(input logic [11:0] a, input logic [1:0] cpu, input logic [63:0] ed, input string tag);
      acc(1'b0, a, 64'h0, cpu, 1'b0, 1'b1, ed, tag, 4'h0);
   endtask

   task automatic wr(input logic [11:0] a, input logic [63:0] d, input string tag);
      acc(1'b1, a, d, 2'd0, 1'b0, 1'b0, 64'h0, tag, 4'h0);
   endtask

   task automatic wr_misc(input logic [63:0] d, input string tag);
      wr(12'h080, d, tag);
      exp_misc = misc_apply(exp_misc, d);
   endtask

   task automatic lines(input logic [63:0] v, input logic leg);
      @(negedge clk);
      dev_lvl = v; legacy_irq = leg;
      @(negedge clk);
   endtask

   // monitor
   always @(posedge clk) acc_q <= reg_req;

   always @(negedge clk) begin
      if (acc_q) begin
         if (sb.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL scoreboard: actual response expected none");
         end else begin
            item_t it;
            it = sb.pop_front();
            check({it.tag, " err"}, {63'h0, reg_err}, {63'h0, it.err});
            if (it.chk_data) check({it.tag, " data"}, reg_rdata, it.data);
         end
      end
   end

   initial begin
      #(4 * 100000);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state: R9, R10, R4
      check("R3 reset hw_irq", {60'h0, hw_irq}, 64'h0);
      check("R8 reset ipi_irq", {60'h0, ipi_irq}, 64'h0);
      check("R11 reset tmr_irq", {60'h0, tmr_irq}, 64'h0);
      rd(12'h080, 2'd2, 64'h0000_0008_0000_0002, "R9 R10 misc reset");
      rd(12'h640, 2'd0, 64'h0, "R4 mask3 reset");

      // masks and raw capture: R1 R2 R3 R4
      wr(12'h200, 64'h0000_0000_0000_00FF, "R4 mask0 write");
      wr(12'h600, 64'h0080_0000_0000_0000, "R4 mask2 write");
      wr(12'h240, 64'hF000_0000_0000_0000, "R4 mask1 write");
      rd(12'h240, 2'd1, 64'hF000_0000_0000_0000, "R4 mask1 readback");
      lines(64'h0000_0000_0000_000F, 1'b0);
      check("R3 hw_irq low lines", {60'h0, hw_irq}, 64'h1);
      rd(12'h300, 2'd0, 64'h0000_0000_0000_000F, "R1 R2 raw read");
      rd(12'h280, 2'd0, 64'h0000_0000_0000_000F, "R2 view0");
      rd(12'h680, 2'd0, 64'h0, "R2 view2 empty");

      // line 55 ignored, cascade drives bit 55: R1
      lines(64'h0080_0000_0000_0000, 1'b0);
      check("R1 dev line 55 ignored", {60'h0, hw_irq}, 64'h0);
      rd(12'h300, 2'd0, 64'h0, "R1 raw without cascade");
      lines(64'h8000_0000_0000_0001, 1'b1);
      check("R1 R3 cascade steers", {60'h0, hw_irq}, 64'h7);
      rd(12'h6C0, 2'd0, 64'h0, "R2 view3 no mask");
      rd(12'h2C0, 2'd0, 64'h8000_0000_0000_0000, "R2 view1");

      // read-only views ignore writes: R2
      wr(12'h300, 64'hFFFF_FFFF_FFFF_FFFF, "R2 raw write");
      wr(12'h280, 64'hFFFF_FFFF_FFFF_FFFF, "R2 view write");
      rd(12'h300, 2'd0, 64'h8080_0000_0000_0001, "R2 raw unchanged");
      rd(12'h200, 2'd0, 64'h0000_0000_0000_00FF, "R2 mask0 untouched by view write");

      // same cycle: line drops while mask written: R3
      @(negedge clk);
      dev_lvl = 64'h0;
      wr(12'h200, 64'h0000_0000_0000_0000, "R3 mask0 clear");
      check("R3 line drop plus mask write", {60'h0, hw_irq}, 64'h4);

      // inter-processor requests: R5 R8 R10
      wr_misc(64'h0000_0000_0000_F000, "R8 ipi request");
      check("R8 ipi all", {60'h0, ipi_irq}, 64'hF);
      rd(12'h080, 2'd1, exp_misc | 64'd1, "R8 R10 misc read cpu1");
      wr_misc(64'h0000_0000_0000_0500, "R5 ipi clear");
      check("R5 ipi partial clear", {60'h0, ipi_irq}, 64'hA);
      wr_misc(64'h0000_0000_0000_1100, "R8 set beats clear");
      check("R8 set beats clear", {60'h0, ipi_irq}, 64'hB);

      // arbitration fields: R6 R7
      wr_misc(64'h0000_0000_00A5_0000, "R7 arb set");
      rd(12'h080, 2'd3, exp_misc | 64'd3, "R7 arb both set");
      wr_misc(64'h0000_0000_0003_0000, "R7 low field held");
      rd(12'h080, 2'd0, exp_misc, "R7 low field nonzero unchanged");
      wr_misc(64'h0000_0000_0010_0000, "R6 arb clear");
      rd(12'h080, 2'd0, exp_misc, "R6 arb cleared");
      wr_misc(64'h0000_0000_0006_0000, "R7 low field from zero");
      rd(12'h080, 2'd0, exp_misc, "R7 low field set");

      // plain field and revision bit: R9
      wr_misc(64'h0000_0A00_0000_0000, "R9 rw field");
      rd(12'h080, 2'd0, exp_misc, "R9 rw field readback");
      wr_misc(64'h0000_0000_0000_0000, "R9 rw field zero");
      rd(12'h080, 2'd0, exp_misc, "R9 revision kept");

      // timer pending: R11
      @(negedge clk);
      tmr_set = 4'b0101;
      @(negedge clk);
      tmr_set = 4'b0000;
      exp_misc |= 64'h50;
      check("R11 timer set", {60'h0, tmr_irq}, 64'h5);
      wr_misc(64'h0000_0000_0000_0010, "R11 timer clear");
      check("R11 timer dropped", {60'h0, tmr_irq}, 64'h4);
      acc(1'b1, 12'h080, 64'h0000_0000_0000_0040, 2'd0, 1'b0, 1'b0, 64'h0, "R11 collide", 4'b0100);
      exp_misc = misc_apply(exp_misc, 64'h40) | 64'h40;
      check("R11 tick beats clear", {60'h0, tmr_irq}, 64'h4);
      rd(12'h080, 2'd0, exp_misc, "R11 misc after collision");

      // errors and reserved offsets: R12
      acc(1'b0, 12'h0C8, 64'h0, 2'd0, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, "R12 unaligned read", 4'h0);
      acc(1'b0, 12'h800, 64'h0, 2'd0, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, "R12 unlisted read", 4'h0);
      acc(1'b1, 12'h208, 64'h1234, 2'd0, 1'b1, 1'b0, 64'h0, "R12 bad write", 4'h0);
      rd(12'h200, 2'd0, 64'h0, "R12 mask0 untouched");
      rd(12'h040, 2'd0, 64'h0, "R12 reserved reads zero");
      wr(12'h000, 64'hFFFF, "R12 reserved write no error");

      repeat (3) @(negedge clk);
      check("scoreboard drained", 64'(sb.size()), 64'h0);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule